// File: doc/BRIEF.md
# Cascadable Fall-Through Strobe FIFO

This block is a first-in first-out buffer of 64 words. Its word width is a parameter, 4 bits by default, and it can be built 5 bits wide. A producer loads a word by pulsing a shift-in strobe. The oldest stored word moves to an output register by itself, with no read request. A consumer takes the word by pulsing a shift-out strobe, and the next word then moves up to the output.

Two readiness flags serve both as status and as handshake. The input flag says a word can be taken. The output flag says the output holds a valid word. Because of this, instances chain for depth without glue logic: the downstream input flag drives the upstream shift-out, and the upstream output flag drives the downstream shift-in. Instances placed side by side for width combine their flags with AND gates.

A synchronous master clear empties the buffer. An output enable, present when a parameter selects it, puts the data outputs in high impedance. The design uses a single clock, and the strobes are sampled at each rising edge.

Top module: `strobe_fifo`

## Requirements
- R1: While `clr` is high at a rising edge the buffer empties: after that edge `out_rdy` is 0 and `in_rdy` is 1.
- R2: A word written with `shin_stb` into an empty buffer appears on `dout` with `out_rdy` = 1 after exactly one rising edge.
- R3: Words leave on `dout` in the order in which they were accepted, across any interleaving of shift-in and shift-out strobes.
- R4: The buffer holds exactly DEPTH (64) words. `in_rdy` is 0 when it holds DEPTH words and `shout_stb` is 0, and 1 in every other case.
- R5: `out_rdy` is 1 exactly when at least one word is stored, and 0 when the buffer is empty.
- R6: A `shout_stb` while `out_rdy` = 1 discards the word on `dout`. After the edge, the next stored word is shown, or `out_rdy` falls if no word is left.
- R7: A `shin_stb` while `in_rdy` = 0 is ignored: neither the stored words nor their count change.
- R8: A `shout_stb` while `out_rdy` = 0 is ignored: the buffer stays empty, and a later write behaves as in R2.
- R9: On a full buffer, a `shin_stb` and a `shout_stb` in the same cycle both complete. `in_rdy` is 1 during that cycle, and the count stays DEPTH.
- R10: With HAS_OE = 1 and `dout_en` = 0, every bit of `dout` is high impedance. With `dout_en` = 1, `dout` carries the output word.
- R11: A clear in the middle of operation discards all stored words, including a full buffer's contents.
- R12: Two instances chained through their flags (downstream `in_rdy` to upstream `shout_stb`, upstream `out_rdy` to downstream `shin_stb`, upstream `dout` to downstream `din`) act as one FIFO of twice the depth that keeps word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous active-high master clear |
| shin_stb | input | 1 | Shift-in strobe, one cycle per word |
| din | input | WIDTH | Word to load |
| in_rdy | output | 1 | Buffer can accept a word this cycle |
| shout_stb | input | 1 | Shift-out strobe, discards the output word |
| out_rdy | output | 1 | `dout` holds a valid word |
| dout_en | input | 1 | Output enable; 0 puts `dout` in high impedance (HAS_OE = 1) |
| dout | output | WIDTH | Oldest stored word |

## Verification
The buffer is driven with a single write into an empty buffer, which exposes the fall-through latency, and with a 64-word fill, which locates the capacity limit exactly. Extra writes on a full buffer and reads on an empty one show that ignored strobes change nothing. Simultaneous strobes on a full buffer separate the combined accept path from a plain full flag. A long interleaved sweep with strobe rates that do not divide each other compares every output word and flag against an arithmetic queue model, so that ordering and pointer wrap past the 63-entry store are checked together. A pair of small chained instances, filled and then drained, shows that depth adds up across the handshake without losing or repeating a word.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    // Action applied to the output register at the next edge
    typedef enum logic [1:0] {
        OS_HOLD     = 2'd0,
        OS_LOAD_MEM = 2'd1,
        OS_LOAD_IN  = 2'd2,
        OS_EMPTY    = 2'd3
    } os_act_e;

    // Per-cycle decisions shared by store, pointers and output stage
    typedef struct packed {
        logic    mem_wr;
        logic    mem_rd;
        os_act_e os_act;
    } step_t;

    // Increment with wrap at a limit that need not be a power of two
    function automatic int unsigned wrap_next(input int unsigned p, input int unsigned lim);
        return (p + 1 >= lim) ? 0 : p + 1;
    endfunction

    // Decide the movement of words for one cycle
    function automatic step_t plan_step(input logic si, input logic so, input logic ov,
                                        input logic mem_empty, input logic full);
        step_t s;
        logic  pop, push, vacate, bypass;
        pop    = so & ov;
        push   = si & (~full | pop);
        vacate = ~ov | pop;
        bypass = push & vacate & mem_empty;
        s.mem_rd = vacate & ~mem_empty;
        s.mem_wr = push & ~bypass;
        if (s.mem_rd)      s.os_act = OS_LOAD_MEM;
        else if (bypass)   s.os_act = OS_LOAD_IN;
        else if (pop)      s.os_act = OS_EMPTY;
        else               s.os_act = OS_HOLD;
        return s;
    endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int WIDTH = 4,
    parameter int ENTRIES = 63,
    localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PW-1:0]    wr_ptr,
    input  logic [WIDTH-1:0] wr_word,
    input  logic [PW-1:0]    rd_ptr,
    output logic [WIDTH-1:0] rd_word
);

    logic [WIDTH-1:0] cells [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_ptr] <= wr_word;
    end

    assign rd_word = cells[rd_ptr];

endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int MEM_D = DEPTH - 1,
    localparam int PW = (MEM_D > 1) ? $clog2(MEM_D) : 1,
    localparam int CW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          shin_stb,
    input  logic          shout_stb,
    input  logic          out_valid,
    output step_t         step,
    output logic          in_rdy,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr
);

    logic [CW-1:0] mem_cnt;
    logic          full, pop;

    assign full   = out_valid && (mem_cnt == CW'(MEM_D));
    assign pop    = shout_stb & out_valid;
    assign in_rdy = ~full | pop;
    assign step   = plan_step(shin_stb, shout_stb, out_valid, mem_cnt == '0, full);

    always_ff @(posedge clk) begin
        if (clr) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            mem_cnt <= '0;
        end else begin
            if (step.mem_wr) wr_ptr <= PW'(wrap_next(int'(wr_ptr), MEM_D));
            if (step.mem_rd) rd_ptr <= PW'(wrap_next(int'(rd_ptr), MEM_D));
            unique case ({step.mem_wr, step.mem_rd})
                2'b10:   mem_cnt <= mem_cnt + 1'b1;
                2'b01:   mem_cnt <= mem_cnt - 1'b1;
                default: mem_cnt <= mem_cnt;
            endcase
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        clr |=> (mem_cnt == '0 && !out_valid && in_rdy));

    // R2
    fall_lat_chk: assert property (@(posedge clk) disable iff (clr)
        (!out_valid && shin_stb) |=> out_valid);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (clr)
        (mem_cnt == CW'(MEM_D) && !step.mem_rd) |-> !step.mem_wr);

    // R7
    full_ignore_chk: assert property (@(posedge clk) disable iff (clr)
        (full && !shout_stb) |=> (full && $stable(wr_ptr) && $stable(rd_ptr)));

    // R8
    empty_ignore_chk: assert property (@(posedge clk) disable iff (clr)
        (!out_valid && !shin_stb) |=> !out_valid);

    // R9
    full_swap_chk: assert property (@(posedge clk) disable iff (clr)
        (full && shout_stb && shin_stb) |=> full);

endmodule

// File: rtl/sfifo_outstage.sv
module sfifo_outstage
    import sfifo_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  os_act_e          act,
    input  logic [WIDTH-1:0] mem_word,
    input  logic [WIDTH-1:0] in_word,
    output logic [WIDTH-1:0] q,
    output logic             out_valid
);

    always_ff @(posedge clk) begin
        if (clr) begin
            q         <= '0;
            out_valid <= 1'b0;
        end else begin
            unique case (act)
                OS_LOAD_MEM: begin q <= mem_word; out_valid <= 1'b1; end
                OS_LOAD_IN:  begin q <= in_word;  out_valid <= 1'b1; end
                OS_EMPTY:    out_valid <= 1'b0;
                default:     ;
            endcase
        end
    end

    // R6
    head_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (out_valid && act == OS_HOLD) |=> (out_valid && $stable(q)));

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import sfifo_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int DEPTH  = 64,
    parameter bit HAS_OE = 1'b1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             shin_stb,
    input  logic [WIDTH-1:0] din,
    output logic             in_rdy,
    input  logic             shout_stb,
    output logic             out_rdy,
    input  logic             dout_en,
    output logic [WIDTH-1:0] dout
);

    localparam int MEM_D = DEPTH - 1;
    localparam int PW    = (MEM_D > 1) ? $clog2(MEM_D) : 1;

    step_t            step;
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [WIDTH-1:0] mem_word, q;
    logic             out_valid;

    sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .clr(clr), .shin_stb(shin_stb), .shout_stb(shout_stb),
        .out_valid(out_valid), .step(step), .in_rdy(in_rdy),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
    );

    sfifo_store #(.WIDTH(WIDTH), .ENTRIES(MEM_D)) u_store (
        .clk(clk), .wr_en(step.mem_wr), .wr_ptr(wr_ptr), .wr_word(din),
        .rd_ptr(rd_ptr), .rd_word(mem_word)
    );

    sfifo_outstage #(.WIDTH(WIDTH)) u_out (
        .clk(clk), .clr(clr), .act(step.os_act), .mem_word(mem_word),
        .in_word(din), .q(q), .out_valid(out_valid)
    );

    assign out_rdy = out_valid;

    generate
        if (HAS_OE) begin : g_oe
            assign dout = dout_en ? q : 'z;
        end else begin : g_no_oe
            assign dout = q;
        end
    endgenerate

endmodule

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;

    localparam int CLK_P = 10;
    localparam int DEPTH = 64;
    localparam int CDEP  = 4;

    logic clk = 1'b0;
    always #(CLK_P / 2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // main instance
    logic       clr = 1'b1, si = 1'b0, so = 1'b0, oe = 1'b1;
    logic [3:0] din = '0;
    wire  [3:0] dout;
    logic       in_rdy, out_rdy;

    strobe_fifo #(.WIDTH(4), .DEPTH(DEPTH), .HAS_OE(1'b1)) u_strobe_fifo (
        .clk(clk), .clr(clr), .shin_stb(si), .din(din), .in_rdy(in_rdy),
        .shout_stb(so), .out_rdy(out_rdy), .dout_en(oe), .dout(dout)
    );

    // chained pair, 5 bits wide
    logic       c_si = 1'b0, c_so = 1'b0;
    logic [4:0] c_din = '0;
    wire  [4:0] mid_word, c_dout;
    logic       up_in_rdy, up_out_rdy, dn_in_rdy, dn_out_rdy;

    strobe_fifo #(.WIDTH(5), .DEPTH(CDEP), .HAS_OE(1'b1)) u_up (
        .clk(clk), .clr(clr), .shin_stb(c_si), .din(c_din), .in_rdy(up_in_rdy),
        .shout_stb(dn_in_rdy), .out_rdy(up_out_rdy), .dout_en(1'b1), .dout(mid_word)
    );
    strobe_fifo #(.WIDTH(5), .DEPTH(CDEP), .HAS_OE(1'b1)) u_dn (
        .clk(clk), .clr(clr), .shin_stb(up_out_rdy), .din(mid_word), .in_rdy(dn_in_rdy),
        .shout_stb(c_so), .out_rdy(dn_out_rdy), .dout_en(1'b1), .dout(c_dout)
    );

    int model[$];
    int seq_no = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pat(input int k);
        return 4'((k * 7 + 3) % 16);
    endfunction

    // one cycle: drive at the falling edge, check in_rdy, clock, check outputs
    task automatic tick(input logic i_si, input logic i_so, input logic [3:0] d, input string tag);
        bit exp_ir, pop, push;
        si = i_si; so = i_so; din = d;
        #1;
        pop    = i_so && model.size() > 0;
        exp_ir = (model.size() < DEPTH) || pop;
        push   = i_si && exp_ir;
        chk(in_rdy === exp_ir, {tag, " in_rdy"}, int'(in_rdy), int'(exp_ir));
        @(posedge clk);
        if (pop)  void'(model.pop_front());
        if (push) model.push_back(int'(d));
        @(negedge clk);
        chk(out_rdy === (model.size() > 0), {tag, " R5 out_rdy"}, int'(out_rdy), int'(model.size() > 0));
        if (model.size() > 0)
            chk(dout === model[0][3:0], {tag, " R3 dout order"}, int'(dout), model[0]);
        si = 1'b0; so = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired (all requirements) actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        clr = 1'b0;
        // R1 reset state
        chk(out_rdy === 1'b0, "R1 out_rdy after clear", int'(out_rdy), 0);
        chk(in_rdy === 1'b1, "R1 in_rdy after clear", int'(in_rdy), 1);

        // R2 single write into empty, then R6 discard
        tick(1'b1, 1'b0, 4'd9, "R2");
        chk(out_rdy === 1'b1 && dout === 4'd9, "R2 fall-through latency", int'(dout), 9);
        tick(1'b0, 1'b1, 4'd0, "R6");
        chk(out_rdy === 1'b0, "R6 last word discarded", int'(out_rdy), 0);

        // R8 shift-out on empty ignored, then a write behaves normally
        tick(1'b0, 1'b1, 4'd0, "R8");
        tick(1'b0, 1'b1, 4'd0, "R8");
        chk(out_rdy === 1'b0, "R8 empty stays empty", int'(out_rdy), 0);
        tick(1'b1, 1'b0, 4'd5, "R8");
        chk(dout === 4'd5, "R8 write after ignored read", int'(dout), 5);
        tick(1'b0, 1'b1, 4'd0, "R6");

        // R4 fill to capacity
        for (int k = 0; k < DEPTH; k++) tick(1'b1, 1'b0, pat(k), "R4");
        #1;
        chk(in_rdy === 1'b0, "R4 full after DEPTH words", int'(in_rdy), 0);

        // R7 writes on full ignored
        for (int k = 0; k < 3; k++) tick(1'b1, 1'b0, 4'hF, "R7");
        chk(model.size() == DEPTH, "R7 count unchanged", model.size(), DEPTH);

        // R9 simultaneous strobes on full
        for (int k = 0; k < 5; k++) tick(1'b1, 1'b1, pat(100 + k), "R9");
        #1;
        chk(in_rdy === 1'b0, "R9 still full", int'(in_rdy), 0);

        // R10 output enable
        oe = 1'b0; #1;
        chk(dout === 4'bzzzz, "R10 high impedance", int'(dout), 0);
        oe = 1'b1; #1;
        chk(dout === model[0][3:0], "R10 driven again", int'(dout), model[0]);

        // R3/R6 drain in order, then one extra read
        while (model.size() > 0) tick(1'b0, 1'b1, 4'd0, "R6");
        tick(1'b0, 1'b1, 4'd0, "R8");
        chk(out_rdy === 1'b0, "R6 drained empty", int'(out_rdy), 0);

        // R3 interleaved sweep, crosses pointer wrap many times
        for (int k = 0; k < 600; k++)
            tick((k % 3) != 0, (k % 5) < 2 || k > 450, pat(k + 17), "R3");
        for (int k = 0; k < 400; k++)
            tick((k % 7) != 3, (k % 4) == 0, pat(k * 3), "R3");

        // R11 clear mid-operation
        clr = 1'b1;
        @(posedge clk); @(negedge clk);
        clr = 1'b0;
        model.delete();
        chk(out_rdy === 1'b0, "R11 cleared", int'(out_rdy), 0);
        chk(in_rdy === 1'b1, "R11 ready after clear", int'(in_rdy), 1);
        tick(1'b1, 1'b0, 4'd3, "R11");
        chk(dout === 4'd3, "R11 fresh word after clear", int'(dout), 3);

        // R12 chained pair: fill 2*CDEP words
        for (int k = 0; k < 2 * CDEP; k++) begin
            c_si = 1'b1; c_din = 5'(k * 5 + 1);
            @(posedge clk); @(negedge clk);
        end
        c_si = 1'b0;
        repeat (12) @(negedge clk);
        chk(up_in_rdy === 1'b0, "R12 chain full at 2*DEPTH", int'(up_in_rdy), 0);
        chk(dn_out_rdy === 1'b1, "R12 chain output ready", int'(dn_out_rdy), 1);
        c_si = 1'b1; c_din = 5'd31;
        @(posedge clk); @(negedge clk);
        c_si = 1'b0;
        for (int k = 0; k < 2 * CDEP; k++) begin
            int guard = 0;
            while (dn_out_rdy !== 1'b1 && guard < 10) begin
                @(negedge clk); guard++;
            end
            chk(c_dout === 5'(k * 5 + 1), "R12 chain order", int'(c_dout), k * 5 + 1);
            c_so = 1'b1;
            @(posedge clk); @(negedge clk);
            c_so = 1'b0;
        end
        repeat (4) @(negedge clk);
        chk(dn_out_rdy === 1'b0, "R12 chain empty, extra word dropped", int'(dn_out_rdy), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule